// File: doc/BRIEF.md
# Ninth-Bit Serial Receiver

This block receives asynchronous serial characters on a single input line. An enable strobe (`os_tick`) runs at sixteen times the bit rate. The block finds a start bit and confirms it at its centre. It then samples each data bit once at its centre, least significant bit first, and samples a single stop bit last. The length is either eight or nine data bits. When the stop bit has been sampled, the eight data bits go into a read-only holding register and an extra flag bit (`rx_bit8`) is loaded.

In nine-bit mode `rx_bit8` carries the ninth received bit. In eight-bit mode it carries a copy of data bit 7; it is not cleared. A ready flag marks that the holding register has unread data, and it drives an interrupt output when the interrupt enable is high. A one-cycle read strobe takes the character and clears the flag. Two status bits are updated with each character: one reports that the previous character was overwritten unread, the other reports that the stop bit was sampled low.

Top module: `uart9_receiver`

## Requirements
- R1: A frame begins only on an `os_tick` where `rx_in` is 0 and the line was 1 at the previous `os_tick`; a line held low after a frame starts no new frame until it returns high.
- R2: The start bit is re-sampled on the 8th `os_tick` after the starting tick; if it reads 1, the frame is dropped and no output changes.
- R3: With `nine_mode`=0, eight data bits are sampled LSB first, each 16 ticks after the previous sample, and `rx_bit8` is loaded with data bit 7 (`rx_data[7]`).
- R4: With `nine_mode`=1, nine bits are sampled; bits 0..7 go to `rx_data` and the ninth goes to `rx_bit8`. The mode is taken at the starting tick of the frame.
- R5: On the clock edge of the stop-bit sample (16 ticks after the last data sample), `rx_data` and `rx_bit8` are loaded and `rx_full` becomes 1.
- R6: `rx_irq` is 1 exactly when `rx_full` is 1 and `irq_en` is 1.
- R7: A `rd_strobe` cycle clears `rx_full` and `overrun`. If a character completes in the same cycle, the new character is loaded, `rx_full` stays 1 and `overrun` stays 0.
- R8: A character that completes while `rx_full` is 1 and no read is strobed overwrites the data and sets `overrun`.
- R9: `frame_err` is loaded with each character: 1 when its stop bit was sampled 0, 0 when it was sampled 1.
- R10: After reset `rx_data`, `rx_bit8`, `rx_full`, `overrun`, `frame_err` and `rx_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial line, idle high, synchronous to clk |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| nine_mode | input | 1 | 1 = nine data bits, 0 = eight |
| irq_en | input | 1 | Interrupt enable for the ready flag |
| rd_strobe | input | 1 | One-cycle read of the holding register |
| rx_data | output | 8 | Received data bits 0..7 |
| rx_bit8 | output | 1 | Ninth bit, or copy of bit 7 in eight-bit mode |
| rx_full | output | 1 | Holding register has unread data |
| overrun | output | 1 | A character was overwritten unread |
| frame_err | output | 1 | Last character's stop bit sampled low |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Two events can fall in the same clock: the completion of a character and a read strobe from the host. To provoke this, the bench leaves one character unread and then raises `rd_strobe` in the cycle that carries the stop-bit tick of the next frame. The correct result is the new data in the holding register, `rx_full` still 1 and `overrun` still 0. The same window with no read strobe must instead set `overrun`. A behavioural model that counts ticks from the start edge judges both cases on every clock.

// File: rtl/uart9_rx_pkg.sv
package uart9_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/uart9_rx_sampler.sv
module uart9_rx_sampler
  import uart9_rx_pkg::*;
#(
  parameter int OS = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_in,
  input  logic          os_tick,
  input  logic          nine_mode,
  output logic          char_done,
  output logic          stop_ok,
  output logic [DW-1:0] char_data,
  output logic          char_bit8,
  output logic          char_nine
);
  localparam int CW   = $clog2(OS);
  localparam int HALF = OS / 2;
  localparam int IW   = $clog2(DW + 1);

  rx_state_t     state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW:0]   sh;
  logic          line_prev;
  logic          nine_lat;

  // index of the final data bit for the latched length
  function automatic logic [IW-1:0] last_idx(input logic nine);
    return nine ? IW'(DW) : IW'(DW - 1);
  endfunction

  // split the shift register into {bit8, data}
  function automatic logic [DW:0] split_char(input logic [DW:0] s, input logic nine);
    return nine ? s : {s[DW], s[DW:1]};
  endfunction

  wire start_edge = os_tick && (state == RX_IDLE) && line_prev && !rx_in;
  wire mid_start  = os_tick && (state == RX_START) && (cnt == CW'(HALF - 1));
  wire full_bit   = os_tick && (cnt == CW'(OS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      idx       <= '0;
      sh        <= '0;
      line_prev <= 1'b1;
      nine_lat  <= 1'b0;
    end else if (os_tick) begin
      line_prev <= rx_in;
      unique case (state)
        RX_IDLE: begin
          if (start_edge) begin
            state    <= RX_START;
            cnt      <= '0;
            nine_lat <= nine_mode;
          end
        end
        RX_START: begin
          if (mid_start) begin
            cnt <= '0;
            idx <= '0;
            state <= rx_in ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (full_bit) begin
            cnt <= '0;
            sh  <= {rx_in, sh[DW:1]};
            if (idx == last_idx(nine_lat)) state <= RX_STOP;
            else idx <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (full_bit) begin
            cnt   <= '0;
            state <= RX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign char_done = full_bit && (state == RX_STOP);
  assign stop_ok   = rx_in;
  assign {char_bit8, char_data} = split_char(sh, nine_lat);
  assign char_nine = nine_lat;

  // R1
  start_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_edge |=> state == RX_START);

  // R2
  glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_start && rx_in) |=> state == RX_IDLE);

endmodule

// File: rtl/uart9_rx_holding.sv
module uart9_rx_holding #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_done,
  input  logic          stop_ok,
  input  logic [DW-1:0] char_data,
  input  logic          char_bit8,
  input  logic          char_nine,
  input  logic          rd_strobe,
  input  logic          irq_en,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit8,
  output logic          rx_full,
  output logic          overrun,
  output logic          frame_err,
  output logic          rx_irq
);
  wire lost_char = char_done && rx_full && !rd_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_bit8   <= 1'b0;
      rx_full   <= 1'b0;
      overrun   <= 1'b0;
      frame_err <= 1'b0;
    end else if (char_done) begin
      rx_data   <= char_data;
      rx_bit8   <= char_bit8;
      rx_full   <= 1'b1;
      overrun   <= lost_char;
      frame_err <= !stop_ok;
    end else if (rd_strobe) begin
      rx_full <= 1'b0;
      overrun <= 1'b0;
    end
  end

  assign rx_irq = rx_full && irq_en;

  // R5
  load_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> rx_full);

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !char_done) |=> (!rx_full && !overrun));

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rx_full && !rd_strobe) |=> overrun);

  // R9
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> frame_err == !$past(stop_ok));

  // R3
  bit7_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !char_nine) |=> rx_bit8 == rx_data[DW-1]);

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> irq_en);

endmodule

// File: rtl/uart9_receiver.sv
module uart9_receiver #(
  parameter int OS = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_in,
  input  logic          os_tick,
  input  logic          nine_mode,
  input  logic          irq_en,
  input  logic          rd_strobe,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit8,
  output logic          rx_full,
  output logic          overrun,
  output logic          frame_err,
  output logic          rx_irq
);
  logic          char_done;
  logic          stop_ok;
  logic [DW-1:0] char_data;
  logic          char_bit8;
  logic          char_nine;

  uart9_rx_sampler #(.OS(OS), .DW(DW)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_in     (rx_in),
    .os_tick   (os_tick),
    .nine_mode (nine_mode),
    .char_done (char_done),
    .stop_ok   (stop_ok),
    .char_data (char_data),
    .char_bit8 (char_bit8),
    .char_nine (char_nine)
  );

  uart9_rx_holding #(.DW(DW)) u_holding (
    .clk       (clk),
    .rst_n     (rst_n),
    .char_done (char_done),
    .stop_ok   (stop_ok),
    .char_data (char_data),
    .char_bit8 (char_bit8),
    .char_nine (char_nine),
    .rd_strobe (rd_strobe),
    .irq_en    (irq_en),
    .rx_data   (rx_data),
    .rx_bit8   (rx_bit8),
    .rx_full   (rx_full),
    .overrun   (overrun),
    .frame_err (frame_err),
    .rx_irq    (rx_irq)
  );

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!rx_full && !overrun && !frame_err));

endmodule

// File: tb/sim_uart9_receiver.sv
module sim_uart9_receiver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       os_tick = 1'b0;
  logic       nine_mode = 1'b0;
  logic       irq_en = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit8, rx_full, overrun, frame_err, rx_irq;

  int total = 0;
  int bad = 0;
  int tdiv = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  uart9_receiver u0 (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick),
    .nine_mode(nine_mode), .irq_en(irq_en), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_full(rx_full),
    .overrun(overrun), .frame_err(frame_err), .rx_irq(rx_irq)
  );

  // behavioural reference: ticks counted from the start edge
  bit m_busy = 0;
  int m_k = 0;
  int m_nb = 8;
  bit m_nine = 0;
  bit m_prev = 1;
  bit m_bits[9];
  bit [7:0] m_data = 0;
  bit m_b8 = 0, m_full = 0, m_ov = 0, m_fe = 0;

  always @(posedge clk) begin
    bit done;
    bit stopv;
    done = 0;
    stopv = 0;
    if (!rst_n) begin
      m_busy = 0; m_prev = 1; m_data = 0; m_b8 = 0;
      m_full = 0; m_ov = 0; m_fe = 0;
    end else begin
      if (os_tick) begin
        if (!m_busy) begin
          if (m_prev && !rx_in) begin
            m_busy = 1; m_k = 0; m_nine = nine_mode; m_nb = nine_mode ? 9 : 8;
          end
        end else begin
          m_k++;
          if (m_k == 8) begin
            if (rx_in) m_busy = 0;
          end else if (m_k > 8 && ((m_k - 8) % 16) == 0) begin
            int j;
            j = (m_k - 8) / 16 - 1;
            if (j < m_nb) m_bits[j] = rx_in;
            else begin done = 1; stopv = rx_in; m_busy = 0; end
          end
        end
        m_prev = rx_in;
      end
      if (done) begin
        for (int i = 0; i < 8; i++) m_data[i] = m_bits[i];
        m_b8 = m_nine ? m_bits[8] : m_bits[7];
        m_ov = m_full && !rd_strobe;
        m_full = 1;
        m_fe = !stopv;
      end else if (rd_strobe) begin
        m_full = 0;
        m_ov = 0;
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(rx_data, m_data, "R3/R4 data vs model");
      chk(rx_bit8, m_b8, "R3/R4 bit8 vs model");
      chk(rx_full, m_full, "R5 full vs model");
      chk(rx_irq, m_full && irq_en, "R6 irq vs model");
      chk(overrun, m_ov, "R8 overrun vs model");
      chk(frame_err, m_fe, "R9 frame_err vs model");
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    os_tick = (tdiv == 0);
  endtask

  task automatic hold(input bit v, input int n, input int rd_at);
    int t;
    t = 0;
    while (t < n) begin
      step();
      rx_in = v;
      rd_strobe = 0;
      if (os_tick) begin
        t++;
        if (t == rd_at) rd_strobe = 1;
      end
    end
  endtask

  task automatic send(input int val, input int nb, input bit stopv, input bit rd_stop, input int tail);
    hold(0, 16, 0);
    for (int i = 0; i < nb; i++) hold(bit'((val >> i) & 1), 16, 0);
    hold(stopv, 16, rd_stop ? 9 : 0);
    if (tail > 0) hold(0, tail, 0);
    hold(1, 32, 0);
  endtask

  task automatic do_read();
    step(); rx_in = 1; rd_strobe = 1;
    step(); rd_strobe = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R5 watchdog actual=hung expected=complete");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) step();
    rst_n = 1;
    step();
    // R10
    chk(rx_data, 0, "R10 reset data");
    chk(rx_bit8, 0, "R10 reset bit8");
    chk({rx_full, overrun, frame_err, rx_irq}, 0, "R10 reset flags");
    hold(1, 32, 0);

    // R3: eight-bit, bit 7 = 1
    send(8'hA5, 8, 1, 0, 0);
    chk(rx_data, 8'hA5, "R3 data A5");
    chk(rx_bit8, 1, "R3 bit8 copies bit7=1");
    chk(rx_full, 1, "R5 full set");
    chk(rx_irq, 0, "R6 irq masked");
    do_read();
    chk(rx_full, 0, "R7 read clears full");
    send(8'h35, 8, 1, 0, 0);
    chk(rx_bit8, 0, "R3 bit8 copies bit7=0");
    do_read();

    // R4: nine-bit
    irq_en = 1; nine_mode = 1;
    send(9'h13C, 9, 1, 0, 0);
    chk(rx_data, 8'h3C, "R4 data 3C");
    chk(rx_bit8, 1, "R4 ninth bit 1");
    chk(rx_irq, 1, "R6 irq asserted");
    do_read();
    chk(rx_irq, 0, "R6 irq drops after read");
    send(9'h0C3, 9, 1, 0, 0);
    chk(rx_data, 8'hC3, "R4 data C3");
    chk(rx_bit8, 0, "R4 ninth bit 0");
    do_read();
    nine_mode = 0;

    // R9 and R1: stop low, line held low afterwards
    send(8'h5A, 8, 0, 0, 48);
    chk(frame_err, 1, "R9 stop low");
    chk(rx_data, 8'h5A, "R9 data kept");
    chk(overrun, 0, "R1 no restart on held-low line");
    do_read();
    send(8'h5A, 8, 1, 0, 0);
    chk(frame_err, 0, "R9 stop high");
    do_read();

    // R8 overrun
    send(8'h11, 8, 1, 0, 0);
    send(8'h22, 8, 1, 0, 0);
    chk(overrun, 1, "R8 overrun set");
    chk(rx_data, 8'h22, "R8 newer data kept");
    do_read();
    chk(overrun, 0, "R7 read clears overrun");
    chk(rx_full, 0, "R7 read clears full after overrun");

    // R7 collision: read in the completion cycle
    send(8'h44, 8, 1, 0, 0);
    send(8'h77, 8, 1, 1, 0);
    chk(rx_data, 8'h77, "R7 collision data");
    chk(rx_full, 1, "R7 collision full stays");
    chk(overrun, 0, "R7 collision no overrun");
    do_read();

    // R2 glitch
    hold(0, 4, 0);
    hold(1, 48, 0);
    chk(rx_full, 0, "R2 glitch ignored full");
    chk(rx_data, 8'h77, "R2 glitch ignored data");

    hold(1, 8, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule